// File: doc/BRIEF.md
# Host Port Resume Sequencer

This block owns the resume handshake of a single USB 2.0 host port. It keeps a force-resume bit that software can read and write through the port control register. Resume begins when software writes a one to that bit, or when the port is suspended and the downstream device signals remote wakeup by moving the line from J to K. While the bit is set the port drives K, and the block itself times the resume interval. At the end it clears the bit and reports which idle state, high-speed or full-speed, the port returns to. A software write of zero cannot end resume early.

A microframe tick generator runs alongside. It produces start-of-frame ticks whenever the controller run/stop bit is one, whether or not the port is suspended. This way, if the controller is already running when resume completes, the first frame follows well inside the device's 3 ms timeout. The resume length and the microframe period are parameters given in clock cycles, so a bench can shorten both.

Top module: `usb_port_resume_ctl`

## Requirements
- R1: With port power on, a register write strobe carrying data 1 sets the force-resume bit. The bit reads 1 from the cycle after the write edge.
- R2: Line state is encoded as 00 = SE0, 01 = J, 10 = K, 11 = reserved. Wakeup is detected when the port is suspended and powered, J has been sampled since the last resume, and K is then sampled on two consecutive edges. On the edge after the second K sample, the bit is set and port-change-detect pulses high for exactly one cycle.
- R3: A K that lasts only one sample, followed by J or SE0, does not set the bit.
- R4: K on the line while the port is not suspended does not set the bit.
- R5: The K-drive enable equals the read value of the force-resume bit in every cycle.
- R6: Once set, the bit reads 1 for exactly RESUME_CYCLES cycles and is then cleared by hardware. In the first cycle it reads 0, the idle pulse is high for one cycle, and the idle-mode output equals the high-speed mode input.
- R7: A write of 0 during resume has no effect; the bit stays set and resume lasts the full RESUME_CYCLES.
- R8: A write of 1 during resume neither restarts nor extends the resume interval.
- R9: While port power is 0, the bit and the K-drive enable read 0, writes are ignored, and a resume in progress is dropped without an idle pulse.
- R10: While run/stop is 1, a one-cycle tick appears every UFRAME_CYCLES cycles, the first one UFRAME_CYCLES cycles after run/stop is sampled high. This holds with the port suspended or not. No tick appears while run/stop is 0.
- R11: A resume started by software never pulses port-change-detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the port control register |
| reg_wdata_fres | input | 1 | Written value of the force-resume bit |
| port_suspended | input | 1 | Port is in the suspend state |
| port_power | input | 1 | Port power is on |
| line_state | input | 2 | Synchronized line state (00 SE0, 01 J, 10 K) |
| hs_mode | input | 1 | 1 = high-speed port, 0 = full-speed |
| run_stop | input | 1 | Controller run/stop bit |
| fres_rd | output | 1 | Read value of the force-resume bit |
| k_drive | output | 1 | Drive K on the port |
| pcd_set | output | 1 | One-cycle set pulse for port-change-detect |
| idle_pulse | output | 1 | One-cycle pulse when resume completes |
| idle_hs | output | 1 | Idle mode on completion: 1 high-speed, 0 full-speed |
| sof_tick | output | 1 | Start-of-frame microframe tick |

## Verification
The checker watches four things in every cycle:
- K-drive tracks the read bit.
- Nothing is read or driven without port power.
- Port-change-detect pulses are single cycles and coincide with a set bit.
- The bit only falls together with the idle pulse, never lasts past RESUME_CYCLES, and ticks never stop while run/stop holds.

The bench's scenarios cover what needs a sequence of inputs. These are the two-sample K filter against glitches and against a non-suspended port, the exact resume length when writes of 0 or 1 land at swept offsets, abortion on power loss, and the tick phase after run/stop rises in each suspend state.

// File: rtl/prc_pkg.sv
package prc_pkg;
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_RSV = 2'b11
   } prc_line_e;

   function automatic logic is_k(input logic [1:0] ls);
      return ls == LS_K;
   endfunction

   function automatic logic is_j(input logic [1:0] ls);
      return ls == LS_J;
   endfunction
endpackage

// File: rtl/prc_kfilter.sv
module prc_kfilter
   import prc_pkg::*;
#(
   parameter int KFILT_LEN = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       arm_clr,
   output logic       j_armed,
   output logic       k_steady
);
   if (KFILT_LEN < 1) begin : g_bad_len
      $error("prc_kfilter: KFILT_LEN must be at least 1");
   end

   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                arm_q <= 1'b0;
      else if (arm_clr)          arm_q <= 1'b0;
      else if (is_j(line_state)) arm_q <= 1'b1;
   end
   assign j_armed = arm_q;

   if (KFILT_LEN == 1) begin : g_single
      logic k_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) k_q <= 1'b0;
         else        k_q <= is_k(line_state);
      end
      assign k_steady = k_q;
   end else begin : g_shift
      logic [KFILT_LEN-1:0] k_sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) k_sr <= '0;
         else        k_sr <= {k_sr[KFILT_LEN-2:0], is_k(line_state)};
      end
      assign k_steady = &k_sr;
   end
endmodule

// File: rtl/prc_resume_core.sv
module prc_resume_core #(
   parameter int RESUME_CYCLES = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic port_power,
   input  logic sw_set,
   input  logic wake,
   input  logic hs_mode,
   output logic fres_q,
   output logic pcd_q,
   output logic idle_q,
   output logic idle_hs_q
);
   localparam int RES_W = (RESUME_CYCLES > 2) ? $clog2(RESUME_CYCLES) : 1;
   localparam logic [RES_W-1:0] RES_LAST = RES_W'(RESUME_CYCLES - 1);

   if (RESUME_CYCLES < 2) begin : g_bad_res
      $error("prc_resume_core: RESUME_CYCLES must be at least 2");
   end

   logic [RES_W-1:0] res_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fres_q    <= 1'b0;
         pcd_q     <= 1'b0;
         idle_q    <= 1'b0;
         idle_hs_q <= 1'b0;
         res_cnt   <= '0;
      end else begin
         pcd_q  <= 1'b0;
         idle_q <= 1'b0;
         if (!port_power) begin
            fres_q  <= 1'b0;
            res_cnt <= '0;
         end else if (fres_q) begin
            if (res_cnt == RES_LAST) begin
               fres_q    <= 1'b0;
               res_cnt   <= '0;
               idle_q    <= 1'b1;
               idle_hs_q <= hs_mode;
            end else begin
               res_cnt <= res_cnt + 1'b1;
            end
         end else if (wake) begin
            fres_q  <= 1'b1;
            res_cnt <= '0;
            pcd_q   <= 1'b1;
         end else if (sw_set) begin
            fres_q  <= 1'b1;
            res_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/prc_sof_gen.sv
module prc_sof_gen #(
   parameter int UFRAME_CYCLES = 15_625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_stop,
   output logic tick_q
);
   localparam int UF_W = (UFRAME_CYCLES > 2) ? $clog2(UFRAME_CYCLES) : 1;
   localparam logic [UF_W-1:0] UF_LAST = UF_W'(UFRAME_CYCLES - 1);

   if (UFRAME_CYCLES < 2) begin : g_bad_uf
      $error("prc_sof_gen: UFRAME_CYCLES must be at least 2");
   end

   logic [UF_W-1:0] uf_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uf_cnt <= '0;
         tick_q <= 1'b0;
      end else if (!run_stop) begin
         uf_cnt <= '0;
         tick_q <= 1'b0;
      end else if (uf_cnt == UF_LAST) begin
         uf_cnt <= '0;
         tick_q <= 1'b1;
      end else begin
         uf_cnt <= uf_cnt + 1'b1;
         tick_q <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_port_resume_ctl.sv
module usb_port_resume_ctl #(
   parameter int RESUME_CYCLES = 2_500_000,
   parameter int UFRAME_CYCLES = 15_625,
   parameter int SOF_GAP_LIMIT = 375_000,
   parameter int KFILT_LEN     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_wdata_fres,
   input  logic       port_suspended,
   input  logic       port_power,
   input  logic [1:0] line_state,
   input  logic       hs_mode,
   input  logic       run_stop,
   output logic       fres_rd,
   output logic       k_drive,
   output logic       pcd_set,
   output logic       idle_pulse,
   output logic       idle_hs,
   output logic       sof_tick
);
   if (UFRAME_CYCLES > SOF_GAP_LIMIT) begin : g_bad_gap
      $error("usb_port_resume_ctl: microframe longer than the post-resume frame limit");
   end

   logic fres_q;
   logic j_armed;
   logic k_steady;
   logic wake;

   assign wake = port_power & port_suspended & j_armed & k_steady & ~fres_q;

   prc_kfilter #(.KFILT_LEN(KFILT_LEN)) u_kfilt (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_state (line_state),
      .arm_clr    (fres_q | wake),
      .j_armed    (j_armed),
      .k_steady   (k_steady)
   );

   prc_resume_core #(.RESUME_CYCLES(RESUME_CYCLES)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_power (port_power),
      .sw_set     (reg_wr & reg_wdata_fres),
      .wake       (wake),
      .hs_mode    (hs_mode),
      .fres_q     (fres_q),
      .pcd_q      (pcd_set),
      .idle_q     (idle_pulse),
      .idle_hs_q  (idle_hs)
   );

   prc_sof_gen #(.UFRAME_CYCLES(UFRAME_CYCLES)) u_sof (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_stop (run_stop),
      .tick_q   (sof_tick)
   );

   assign fres_rd = fres_q & port_power;
   assign k_drive = fres_q & port_power;
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int RESUME_CYCLES = 2_500_000,
   parameter int UFRAME_CYCLES = 15_625
) (
   input logic clk,
   input logic rst_n,
   input logic port_power,
   input logic run_stop,
   input logic fres_rd,
   input logic k_drive,
   input logic pcd_set,
   input logic idle_pulse,
   input logic sof_tick
);
   localparam int RC_W = $clog2(RESUME_CYCLES + 2);
   localparam int GC_W = $clog2(UFRAME_CYCLES + 2);

   logic [RC_W-1:0] res_seen;
   logic [GC_W-1:0] gap_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_seen <= '0;
         gap_seen <= '0;
      end else begin
         res_seen <= fres_rd ? res_seen + 1'b1 : '0;
         gap_seen <= (!run_stop || sof_tick) ? '0 : gap_seen + 1'b1;
      end
   end

   p_kdrive_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      k_drive == fres_rd);

   p_unpowered_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !port_power |-> (!fres_rd && !k_drive));

   p_pcd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pcd_set |=> !pcd_set);

   p_pcd_with_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pcd_set && port_power) |-> fres_rd);

   p_fall_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fres_rd) && port_power && $past(port_power)) |-> idle_pulse);

   p_idle_follows_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> (!fres_rd && $past(fres_rd)));

   p_resume_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fres_rd |-> (res_seen < RC_W'(RESUME_CYCLES)));

   p_tick_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_stop |=> !sof_tick);

   p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gap_seen <= GC_W'(UFRAME_CYCLES));
endmodule

bind usb_port_resume_ctl prc_checker #(
   .RESUME_CYCLES (RESUME_CYCLES),
   .UFRAME_CYCLES (UFRAME_CYCLES)
) u_prc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_power (port_power),
   .run_stop   (run_stop),
   .fres_rd    (fres_rd),
   .k_drive    (k_drive),
   .pcd_set    (pcd_set),
   .idle_pulse (idle_pulse),
   .sof_tick   (sof_tick)
);

// File: tb/tb_usb_port_resume_ctl.sv
module tb_usb_port_resume_ctl;
   localparam int RES = 40;
   localparam int UF  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_wdata_fres = 1'b0;
   logic       port_suspended = 1'b0;
   logic       port_power = 1'b1;
   logic [1:0] line_state = 2'b01;
   logic       hs_mode = 1'b0;
   logic       run_stop = 1'b0;
   logic       fres_rd, k_drive, pcd_set, idle_pulse, idle_hs, sof_tick;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   usb_port_resume_ctl #(
      .RESUME_CYCLES (RES),
      .UFRAME_CYCLES (UF),
      .SOF_GAP_LIMIT (100),
      .KFILT_LEN     (2)
   ) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr         (reg_wr),
      .reg_wdata_fres (reg_wdata_fres),
      .port_suspended (port_suspended),
      .port_power     (port_power),
      .line_state     (line_state),
      .hs_mode        (hs_mode),
      .run_stop       (run_stop),
      .fres_rd        (fres_rd),
      .k_drive        (k_drive),
      .pcd_set        (pcd_set),
      .idle_pulse     (idle_pulse),
      .idle_hs        (idle_hs),
      .sof_tick       (sof_tick)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Software write; returns at the negedge after the write edge.
   task automatic sw_write(input logic d);
      reg_wr = 1'b1;
      reg_wdata_fres = d;
      step();
      reg_wr = 1'b0;
      reg_wdata_fres = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < RES + 4 && fres_rd; i++) step();
      step();
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int len;
      bit saw_pcd;
      bit saw_idle;
      bit kd_ok;
      int offs [3];
      offs[0] = 2;
      offs[1] = 17;
      offs[2] = RES - 2;

      repeat (3) step();
      chk("R1 reset fres_rd", fres_rd, 0);
      chk("R10 reset sof_tick", sof_tick, 0);
      chk("R2 reset pcd_set", pcd_set, 0);
      rst_n = 1'b1;
      step();

      // R6 R7 R8 R11: sweep write value, offset, speed mode
      for (int hs = 0; hs < 2; hs++) begin
         for (int d = 0; d < 2; d++) begin
            for (int o = 0; o < 3; o++) begin
               hs_mode = hs[0];
               sw_write(1'b1);
               chk("R1 bit set after write", fres_rd, 1);
               len = 0;
               saw_pcd = 1'b0;
               kd_ok = 1'b1;
               while (fres_rd && len < RES + 10) begin
                  if (k_drive != fres_rd) kd_ok = 1'b0;
                  if (pcd_set) saw_pcd = 1'b1;
                  if (len == offs[o]) begin
                     reg_wr = 1'b1;
                     reg_wdata_fres = d[0];
                  end
                  step();
                  reg_wr = 1'b0;
                  len++;
               end
               if (d == 0) chk("R7 length with write 0", len, RES);
               else        chk("R8 length with write 1", len, RES);
               chk("R5 k_drive tracks bit", kd_ok, 1);
               chk("R6 idle pulse at end", idle_pulse, 1);
               chk("R6 idle mode", idle_hs, hs);
               chk("R11 no pcd on sw resume", saw_pcd, 0);
               step();
               chk("R6 idle pulse one cycle", idle_pulse, 0);
               chk("R6 bit stays clear", fres_rd, 0);
            end
         end
      end

      // R7: write of 0 when idle does nothing
      sw_write(1'b0);
      chk("R7 write 0 idle", fres_rd, 0);

      // R2: remote wake J -> K,K
      port_suspended = 1'b1;
      line_state = 2'b01;
      step(); step();
      line_state = 2'b10;
      step();
      chk("R2 no set after 1 K", fres_rd, 0);
      step();
      chk("R2 no set after 2 K", fres_rd, 0);
      step();
      chk("R2 bit set by wake", fres_rd, 1);
      chk("R2 pcd pulse", pcd_set, 1);
      chk("R5 k_drive on wake", k_drive, 1);
      step();
      chk("R2 pcd single cycle", pcd_set, 0);
      line_state = 2'b01;
      len = 1;
      while (fres_rd && len < RES + 10) begin step(); len++; end
      chk("R6 wake resume length", len, RES);
      step();

      // R3: one-sample K glitch, with J and with SE0 after it
      for (int g = 0; g < 2; g++) begin
         line_state = 2'b01;
         step(); step();
         line_state = 2'b10;
         step();
         line_state = (g == 0) ? 2'b01 : 2'b00;
         saw_pcd = 1'b0;
         len = 0;
         for (int i = 0; i < 6; i++) begin
            step();
            if (fres_rd) len++;
            if (pcd_set) saw_pcd = 1'b1;
         end
         chk("R3 glitch ignored", len, 0);
         chk("R3 glitch no pcd", saw_pcd, 0);
      end

      // R4: not suspended, long K
      port_suspended = 1'b0;
      line_state = 2'b01;
      step(); step();
      line_state = 2'b10;
      len = 0;
      for (int i = 0; i < 8; i++) begin step(); if (fres_rd) len++; end
      chk("R4 K ignored when not suspended", len, 0);
      line_state = 2'b01;
      step();

      // R9: power loss aborts resume, writes ignored without power
      sw_write(1'b1);
      repeat (5) step();
      port_power = 1'b0;
      #1;
      chk("R9 bit reads 0 without power", fres_rd, 0);
      chk("R9 no K without power", k_drive, 0);
      saw_idle = 1'b0;
      for (int i = 0; i < RES + 5; i++) begin step(); if (idle_pulse) saw_idle = 1'b1; end
      chk("R9 no idle pulse on abort", saw_idle, 0);
      sw_write(1'b1);
      chk("R9 write ignored unpowered", fres_rd, 0);
      port_power = 1'b1;
      step(); step();
      chk("R9 bit clear after power back", fres_rd, 0);

      // R9: wake ignored without power
      port_power = 1'b0;
      port_suspended = 1'b1;
      line_state = 2'b01;
      step(); step();
      line_state = 2'b10;
      saw_pcd = 1'b0;
      for (int i = 0; i < 5; i++) begin step(); if (pcd_set) saw_pcd = 1'b1; end
      chk("R9 no wake unpowered", saw_pcd, 0);
      port_power = 1'b1;
      line_state = 2'b01;
      port_suspended = 1'b0;
      step(); step();
      chk("R9 no bit after wake unpowered", fres_rd, 0);

      // R10: stopped -> no ticks
      len = 0;
      for (int i = 0; i < 3 * UF; i++) begin step(); if (sof_tick) len++; end
      chk("R10 no tick when stopped", len, 0);

      // R10: tick phase, suspended and not
      for (int s = 0; s < 2; s++) begin
         port_suspended = s[0];
         run_stop = 1'b1;
         len = 0;
         for (int k = 1; k <= 4 * UF; k++) begin
            step();
            if (sof_tick != ((k % UF) == 0)) len++;
         end
         chk("R10 tick positions", len, 0);
         run_stop = 1'b0;
         step();
         len = 0;
         for (int i = 0; i < 2 * UF; i++) begin step(); if (sof_tick) len++; end
         chk("R10 ticks stop", len, 0);
      end

      // R10 with resume ending while running
      port_suspended = 1'b0;
      run_stop = 1'b1;
      sw_write(1'b1);
      drain();
      len = 0;
      for (int i = 0; i < UF; i++) begin step(); if (sof_tick) len++; end
      chk("R10 tick after resume end", len, 1);
      run_stop = 1'b0;
      step();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule